// File: doc/BRIEF.md
# I/O Space Prefix Access Qualifier

This block sits between the instruction decoder and the bus interface of a small processor core. It turns an ordinary data access into an I/O access when the current instruction carries an I/O prefix. Two prefixes exist: one selects the internal I/O space and the other selects the external I/O space. A prefix applies to exactly one instruction. While it is in force, every data read or write of that instruction goes to the chosen I/O space, at the same 16-bit effective address the memory access would have used. This holds for all addressing forms, so an index value of 4000h plus an offset of 5 reaches I/O location 4005h.

Each accepted request produces one strobe cycle on exactly one of six outputs: memory, internal I/O or external I/O, each with a read and a write strobe. A word request produces two consecutive byte cycles at A and then A+1, and both cycles go to the same space. Instruction-fetch cycles always go to memory. The block also drives an interrupt-inhibit output. After a privileged instruction, such as loading the stack pointer from a register pair, this output keeps the interrupt controller from taking an interrupt until the following instruction has completed.

Top module: `io_prefix_qualifier`

## Requirements
- R1: While reset is held and in the first cycle after it, all six strobes, `seq_busy` and `irq_inhibit` are low, and no prefix is in force.
- R2: A data request (`rd_req` or `wr_req`) with no prefix in force and `seq_busy` low produces, in the next cycle, one memory strobe (`mem_rd` for a read, `mem_wr` for a write) with `bus_addr` equal to the request's `eff_addr`.
- R3: A prefix pulse (`pfx_seen`) with `pfx_sel_ext`=0 selects internal I/O and with `pfx_sel_ext`=1 selects external I/O. The selection applies to requests in the pulse's own cycle and to all later requests up to the end of the instruction.
- R4: In the cycle after `instr_end`, the prefix is no longer in force, unless `pfx_seen` was high in the same cycle as `instr_end`. In that case the new prefix is in force for the next instruction.
- R5: A second prefix pulse before `instr_end` replaces the first: the space chosen by the latest pulse is used.
- R6: A request with `fetch_cyc`=1 always strobes memory, whatever prefix is in force, and it leaves the prefix in force.
- R7: A request with `word_acc`=1 gives a strobe at address A in the next cycle and a strobe at A+1 (modulo 2^16, so FFFFh is followed by 0000h) in the cycle after that. Both strobes are in the same space and have the same direction.
- R8: `seq_busy` is high exactly in the first byte cycle of a word access. A request made in that cycle is ignored: the second byte proceeds unchanged and no further strobe follows.
- R9: If `rd_req` and `wr_req` are both high, the access is a read.
- R10: `instr_end` with `priv_instr`=1 raises `irq_inhibit` from the next cycle. It stays high through the cycle of the next `instr_end` and then takes the `priv_instr` value of that end. `irq_inhibit` changes only in the cycle after an `instr_end`.
- R11: At most one of the six strobes is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pfx_seen | input | 1 | Pulse: the decoder has seen an I/O prefix |
| pfx_sel_ext | input | 1 | Space chosen by the prefix pulse: 0 internal, 1 external |
| eff_addr | input | 16 | Effective address of the data access |
| rd_req | input | 1 | Read request pulse |
| wr_req | input | 1 | Write request pulse |
| word_acc | input | 1 | Request is a 16-bit access (two byte cycles) |
| fetch_cyc | input | 1 | Request is an instruction fetch |
| instr_end | input | 1 | Pulse: the current instruction completes |
| priv_instr | input | 1 | The completing instruction is privileged (valid with `instr_end`) |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| int_io_rd | output | 1 | Internal I/O read strobe |
| int_io_wr | output | 1 | Internal I/O write strobe |
| ext_io_rd | output | 1 | External I/O read strobe |
| ext_io_wr | output | 1 | External I/O write strobe |
| bus_addr | output | 16 | Address of the current strobe cycle |
| seq_busy | output | 1 | First byte of a word access; second byte follows |
| irq_inhibit | output | 1 | Interrupts must not be accepted |

## Verification
The hardest situations to reach are those where several events fall in the same cycle. Examples are a prefix pulse together with `instr_end`, an `instr_end` between the two byte cycles of a prefixed word access, and a fresh request while the second byte is pending. Directed sequences build each of these. Thousands of random cycles follow, in which prefix pulses, end pulses, fetches and word requests arrive with independent probabilities. They are checked every cycle against a cycle model written in the bench, and addresses near FFFFh are drawn often enough to exercise the wrap.

// File: rtl/iopq_pkg.sv
// Package: shared types for the I/O prefix access qualifier.
// Assumes at most three target spaces, coded as below.
package iopq_pkg;
    localparam int NSPACE = 3;

    typedef enum logic [1:0] {
        SPC_MEM   = 2'd0,
        SPC_IOINT = 2'd1,
        SPC_IOEXT = 2'd2
    } space_e;
endpackage

// File: rtl/iopq_prefix_track.sv
// Module: iopq_prefix_track
// Holds the I/O prefix of the current instruction and gives the space that
// a data request made this cycle belongs to. A pulse takes effect in its
// own cycle. A later pulse replaces an earlier one, and instr_end clears
// the state unless a pulse arrives in the same cycle.
// Assumes pfx_sel_ext is valid whenever pfx_seen is high.
module iopq_prefix_track
    import iopq_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   pfx_seen,
    input  logic   pfx_sel_ext,
    input  logic   instr_end,
    output space_e eff_space
);
    logic act_q;
    logic ext_q;

    // Purpose: record or clear the prefix at instruction boundaries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= 1'b0;
            ext_q <= 1'b0;
        end else if (pfx_seen) begin
            act_q <= 1'b1;
            ext_q <= pfx_sel_ext;
        end else if (instr_end) begin
            act_q <= 1'b0;
        end
    end

    // Purpose: resolve the space of a request in this cycle.
    always_comb begin
        if (pfx_seen)
            eff_space = pfx_sel_ext ? SPC_IOEXT : SPC_IOINT;
        else if (act_q)
            eff_space = ext_q ? SPC_IOEXT : SPC_IOINT;
        else
            eff_space = SPC_MEM;
    end

    // R4: an end without a new prefix leaves no prefix behind.
    p_prefix_cleared_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_end && !pfx_seen) |=> !act_q);

    // R5: the latest pulse decides the space.
    p_latest_prefix_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pfx_seen |=> (act_q && ext_q == $past(pfx_sel_ext)));
endmodule

// File: rtl/iopq_byte_seq.sv
// Module: iopq_byte_seq
// Registers one access and issues its byte cycles. A byte access takes one
// strobe cycle. A word access takes two cycles, at A and A+1, in the same
// space and direction. Requests are not accepted while the second byte is
// pending. A read wins when read and write are requested together.
// Assumes the requested space has already been resolved by the caller.
module iopq_byte_seq
    import iopq_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic              wr_req,
    input  logic              word_acc,
    input  logic [ADDR_W-1:0] eff_addr,
    input  space_e            req_space,
    output logic              cyc_act,
    output logic              cyc_wr,
    output space_e            cyc_space,
    output logic [ADDR_W-1:0] cyc_addr,
    output logic              busy
);
    localparam logic [ADDR_W-1:0] ADDR_ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

    logic              act_q;
    logic              wr_q;
    logic              busy_q;
    space_e            sp_q;
    logic [ADDR_W-1:0] addr_q;
    logic              start;

    // Purpose: accept a request only when no second byte is pending.
    always_comb begin
        start = (rd_req || wr_req) && !busy_q;
    end

    // Purpose: step through the byte cycles of the current access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q  <= 1'b0;
            wr_q   <= 1'b0;
            busy_q <= 1'b0;
            sp_q   <= SPC_MEM;
            addr_q <= '0;
        end else if (busy_q) begin
            act_q  <= 1'b1;
            addr_q <= addr_q + ADDR_ONE;
            busy_q <= 1'b0;
        end else if (start) begin
            act_q  <= 1'b1;
            wr_q   <= wr_req && !rd_req;
            sp_q   <= req_space;
            addr_q <= eff_addr;
            busy_q <= word_acc;
        end else begin
            act_q  <= 1'b0;
            busy_q <= 1'b0;
        end
    end

    assign cyc_act   = act_q;
    assign cyc_wr    = wr_q;
    assign cyc_space = sp_q;
    assign cyc_addr  = addr_q;
    assign busy      = busy_q;

    // R7: the second byte follows at the next address in the same space.
    p_second_byte_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |=> (act_q && addr_q == $past(addr_q) + ADDR_ONE
                    && $stable(sp_q) && $stable(wr_q)));

    // R8: a request in the busy cycle does not alter the second byte.
    p_busy_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && (rd_req || wr_req)) |=> (!busy_q && $stable(sp_q)));
endmodule

// File: rtl/iopq_strobe_decode.sv
// Module: iopq_strobe_decode
// Expands the active cycle into one read and one write strobe per space.
// Assumes the space code is one of the NSPACE values in iopq_pkg.
module iopq_strobe_decode
    import iopq_pkg::*;
(
    input  logic              cyc_act,
    input  logic              cyc_wr,
    input  space_e            cyc_space,
    output logic [NSPACE-1:0] rd_vec,
    output logic [NSPACE-1:0] wr_vec
);
    // Purpose: one strobe pair for each target space.
    for (genvar g = 0; g < NSPACE; g++) begin : g_space
        assign rd_vec[g] = cyc_act && (cyc_space == space_e'(g)) && !cyc_wr;
        assign wr_vec[g] = cyc_act && (cyc_space == space_e'(g)) &&  cyc_wr;
    end

    // R11: never more than one strobe.
    always_comb begin
        a_one_strobe_r11: assert ($onehot0({rd_vec, wr_vec}));
    end
endmodule

// File: rtl/iopq_irq_shadow.sv
// Module: iopq_irq_shadow
// Holds off interrupts for one instruction after a privileged one. The
// flag is loaded only at instruction ends, so it covers the whole next
// instruction, including that instruction's end cycle.
// Assumes priv_instr is valid whenever instr_end is high.
module iopq_irq_shadow (
    input  logic clk,
    input  logic rst_n,
    input  logic instr_end,
    input  logic priv_instr,
    output logic irq_inhibit
);
    logic inh_q;

    // Purpose: sample the privilege of each completing instruction.
    always_ff @(posedge clk) begin
        if (!rst_n)
            inh_q <= 1'b0;
        else if (instr_end)
            inh_q <= priv_instr;
    end

    assign irq_inhibit = inh_q;

    // R10: the flag moves only after an instruction end.
    p_inhibit_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_end |=> $stable(irq_inhibit));

    // R10: a privileged end always leaves the flag raised.
    p_inhibit_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_end && priv_instr) |=> irq_inhibit);
endmodule

// File: rtl/io_prefix_qualifier.sv
// Module: io_prefix_qualifier (top)
// Steers data accesses to the memory, internal I/O or external I/O strobes
// according to the one-instruction I/O prefix, sequences word accesses as
// two byte cycles, and produces the interrupt-inhibit after privileged
// instructions. Strobes and bus_addr are registered: they appear in the
// cycle after the request.
// Assumes the decoder holds off new requests while seq_busy is high.
module io_prefix_qualifier
    import iopq_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pfx_seen,
    input  logic              pfx_sel_ext,
    input  logic [ADDR_W-1:0] eff_addr,
    input  logic              rd_req,
    input  logic              wr_req,
    input  logic              word_acc,
    input  logic              fetch_cyc,
    input  logic              instr_end,
    input  logic              priv_instr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              int_io_rd,
    output logic              int_io_wr,
    output logic              ext_io_rd,
    output logic              ext_io_wr,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              seq_busy,
    output logic              irq_inhibit
);
    space_e            eff_space;
    space_e            req_space;
    space_e            cyc_space;
    logic              cyc_act;
    logic              cyc_wr;
    logic [NSPACE-1:0] rd_vec;
    logic [NSPACE-1:0] wr_vec;

    iopq_prefix_track u_prefix (
        .clk        (clk),
        .rst_n      (rst_n),
        .pfx_seen   (pfx_seen),
        .pfx_sel_ext(pfx_sel_ext),
        .instr_end  (instr_end),
        .eff_space  (eff_space)
    );

    // Purpose: fetch cycles are never redirected.
    always_comb begin
        req_space = fetch_cyc ? SPC_MEM : eff_space;
    end

    iopq_byte_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_req   (rd_req),
        .wr_req   (wr_req),
        .word_acc (word_acc),
        .eff_addr (eff_addr),
        .req_space(req_space),
        .cyc_act  (cyc_act),
        .cyc_wr   (cyc_wr),
        .cyc_space(cyc_space),
        .cyc_addr (bus_addr),
        .busy     (seq_busy)
    );

    iopq_strobe_decode u_dec (
        .cyc_act  (cyc_act),
        .cyc_wr   (cyc_wr),
        .cyc_space(cyc_space),
        .rd_vec   (rd_vec),
        .wr_vec   (wr_vec)
    );

    iopq_irq_shadow u_shadow (
        .clk        (clk),
        .rst_n      (rst_n),
        .instr_end  (instr_end),
        .priv_instr (priv_instr),
        .irq_inhibit(irq_inhibit)
    );

    assign mem_rd    = rd_vec[SPC_MEM];
    assign mem_wr    = wr_vec[SPC_MEM];
    assign int_io_rd = rd_vec[SPC_IOINT];
    assign int_io_wr = wr_vec[SPC_IOINT];
    assign ext_io_rd = rd_vec[SPC_IOEXT];
    assign ext_io_wr = wr_vec[SPC_IOEXT];

    // R6: an accepted fetch reads memory in the next cycle.
    p_fetch_mem_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && fetch_cyc && !seq_busy) |=> mem_rd);

    // R9: a request carrying both strobes is a read.
    p_read_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && wr_req && !seq_busy) |=> !(mem_wr || int_io_wr || ext_io_wr));

    // R2: an accepted request puts its address on the bus.
    p_req_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_req || wr_req) && !seq_busy) |=> (bus_addr == $past(eff_addr)));
endmodule

// File: tb/io_prefix_qualifier_bench.sv
// Bench for io_prefix_qualifier: directed corner cases, then random cycles,
// all compared each cycle with a cycle model kept in the bench.
module io_prefix_qualifier_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pfx_seen = 0, pfx_sel_ext = 0, rd_req = 0, wr_req = 0;
    logic        word_acc = 0, fetch_cyc = 0, instr_end = 0, priv_instr = 0;
    logic [15:0] eff_addr = '0;
    logic        mem_rd, mem_wr, int_io_rd, int_io_wr, ext_io_rd, ext_io_wr;
    logic [15:0] bus_addr;
    logic        seq_busy, irq_inhibit;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    // bench model state
    bit        m_pact, m_pext, m_act, m_busy, m_wr, m_inh;
    int        m_sp;
    bit [15:0] m_addr;

    always #4 clk = ~clk;

    io_prefix_qualifier u_io_prefix_qualifier (
        .clk(clk), .rst_n(rst_n), .pfx_seen(pfx_seen), .pfx_sel_ext(pfx_sel_ext),
        .eff_addr(eff_addr), .rd_req(rd_req), .wr_req(wr_req), .word_acc(word_acc),
        .fetch_cyc(fetch_cyc), .instr_end(instr_end), .priv_instr(priv_instr),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .int_io_rd(int_io_rd), .int_io_wr(int_io_wr),
        .ext_io_rd(ext_io_rd), .ext_io_wr(ext_io_wr), .bus_addr(bus_addr),
        .seq_busy(seq_busy), .irq_inhibit(irq_inhibit)
    );

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [5:0] exp_strobes();
        logic [5:0] v = '0;
        if (m_act) v[m_sp*2 + (m_wr ? 1 : 0)] = 1'b1;
        return v;
    endfunction

    task automatic clear_inputs();
        pfx_seen = 0; pfx_sel_ext = 0; rd_req = 0; wr_req = 0;
        word_acc = 0; fetch_cyc = 0; instr_end = 0; priv_instr = 0;
    endtask

    // Advance the model over one clock, then compare at the next negedge.
    task automatic cyc(string ts);
        int  eff;
        bit  second;
        second = m_busy;
        eff = pfx_seen ? (pfx_sel_ext ? 2 : 1) : (m_pact ? (m_pext ? 2 : 1) : 0);
        if (m_busy) begin
            m_act = 1; m_addr = m_addr + 16'd1; m_busy = 0;
        end else if (rd_req || wr_req) begin
            m_act = 1; m_addr = eff_addr; m_sp = fetch_cyc ? 0 : eff;
            m_wr = wr_req && !rd_req; m_busy = word_acc;
        end else begin
            m_act = 0; m_busy = 0;
        end
        if (pfx_seen) begin m_pact = 1; m_pext = pfx_sel_ext; end
        else if (instr_end) m_pact = 0;
        if (instr_end) m_inh = priv_instr;
        @(posedge clk);
        @(negedge clk);
        chk(ts, "strobes", {26'd0, ext_io_wr, ext_io_rd, int_io_wr, int_io_rd, mem_wr, mem_rd},
            {26'd0, exp_strobes()});
        if (m_act) chk(second ? "R7" : ts, "bus_addr", {16'd0, bus_addr}, {16'd0, m_addr});
        chk("R8", "seq_busy", {31'd0, seq_busy}, {31'd0, m_busy});
        chk("R10", "irq_inhibit", {31'd0, irq_inhibit}, {31'd0, m_inh});
        clear_inputs();
    endtask

    task automatic req(bit r, bit w, bit wd, logic [15:0] a);
        rd_req = r; wr_req = w; word_acc = wd; eff_addr = a;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int unsigned seed_v;
        seed_v = $urandom(32'h1F2E3D4C);
        clear_inputs();
        repeat (3) @(negedge clk);
        // R1: outputs quiet in reset
        chk("R1", "strobes in reset", {26'd0, ext_io_wr, ext_io_rd, int_io_wr, int_io_rd, mem_wr, mem_rd}, 32'd0);
        chk("R1", "busy/inhibit in reset", {30'd0, seq_busy, irq_inhibit}, 32'd0);
        rst_n = 1'b1;
        m_pact = 0; m_pext = 0; m_act = 0; m_busy = 0; m_wr = 0; m_inh = 0; m_sp = 0; m_addr = 0;
        cyc("R1");

        // R1/R2: first access after reset goes to memory
        req(1, 0, 0, 16'h1234); cyc("R2");
        req(0, 1, 0, 16'h00A5); cyc("R2");
        // R3: internal prefix then a write
        pfx_seen = 1; pfx_sel_ext = 0; cyc("R3");
        req(0, 1, 0, 16'h0085); cyc("R3");
        instr_end = 1; cyc("R4");
        // R4: prefix gone
        req(1, 0, 0, 16'h0085); cyc("R4");
        // R3 same-cycle pulse + R7 word on external I/O
        pfx_seen = 1; pfx_sel_ext = 1; req(1, 0, 1, 16'h4005); cyc("R3");
        instr_end = 1; cyc("R7");
        cyc("R7");
        // R4: pulse together with the end survives into the next instruction
        pfx_seen = 1; pfx_sel_ext = 0; instr_end = 1; cyc("R4");
        req(1, 0, 0, 16'h0010); cyc("R4");
        instr_end = 1; cyc("R4");
        // R5: later prefix replaces earlier
        pfx_seen = 1; pfx_sel_ext = 0; cyc("R5");
        pfx_seen = 1; pfx_sel_ext = 1; cyc("R5");
        req(0, 1, 0, 16'h2222); cyc("R5");
        // R6: fetch with prefix in force stays in memory, prefix kept
        req(1, 0, 0, 16'h0100); fetch_cyc = 1; cyc("R6");
        req(1, 0, 0, 16'h3333); cyc("R6");
        instr_end = 1; cyc("R4");
        // R7: word wrap at FFFF
        req(0, 1, 1, 16'hFFFF); cyc("R7");
        cyc("R7");
        // R8: request in the busy cycle is ignored
        req(1, 0, 1, 16'h5000); cyc("R8");
        req(0, 1, 0, 16'h7777); cyc("R8");
        cyc("R8");
        // R9: read wins
        req(1, 1, 0, 16'h0042); cyc("R9");
        // R10: privileged end shadows one instruction
        instr_end = 1; priv_instr = 1; cyc("R10");
        cyc("R10");
        cyc("R10");
        instr_end = 1; priv_instr = 0; cyc("R10");
        cyc("R10");

        // Random phase
        for (int i = 0; i < 4000; i++) begin
            string tg;
            pfx_seen    = ($urandom % 8) == 0;
            pfx_sel_ext = $urandom % 2;
            rd_req      = ($urandom % 3) == 0;
            wr_req      = ($urandom % 3) == 0;
            word_acc    = ($urandom % 3) == 0;
            fetch_cyc   = ($urandom % 6) == 0;
            instr_end   = ($urandom % 5) == 0;
            priv_instr  = ($urandom % 3) == 0;
            eff_addr    = (($urandom % 8) == 0) ? 16'hFFFF : 16'($urandom);
            if (m_busy) tg = "R8";
            else if (fetch_cyc && (rd_req || wr_req)) tg = "R6";
            else if (rd_req && wr_req) tg = "R9";
            else tg = "R3";
            cyc(tg);
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule